// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the arithmetic and move-wide stage of a small 64-bit integer core. In the same cycle it turns two register operands, the destination's old value, a 12-bit immediate, a 16-bit immediate and a 2-bit lane select into one 64-bit result. It covers five operations:

- add with immediate
- add that sets flags
- subtract that sets flags
- move-wide with zero fill
- move-wide that keeps the other bits

The result path has no registers. The four condition flags sit in a register that takes a new value at the clock edge only when a flag-setting operation is issued.

The result is a plain output, with no handshake, because the stage has no storage and cannot stall. The `exec_en` pin marks a cycle that carries a real operation. When it is low the result still follows the inputs, but the flags are left alone. A later branch stage reads the flags, together with the `flag_lt` output, which is high when the negative and overflow flags differ.

Top module: `exu_core`

## Requirements
- R1: Operation code 0 (add immediate) drives `result` to `opnd_a` plus `imm12` zero-extended to 64 bits, modulo 2^64, in the same cycle.
- R2: Operation code 1 (add, flag-setting) drives `result` to `opnd_a + opnd_b` modulo 2^64, in the same cycle.
- R3: Operation code 2 (subtract, flag-setting) drives `result` to `opnd_a - opnd_b` modulo 2^64, in the same cycle.
- R4: Operation code 3 (move zero) drives `result` to `imm16` placed at bit 16*`shamt`, with every other bit zero, for `shamt` values 0 to 3.
- R5: Operation code 4 (move keep) drives `result` to `opnd_old` with bits [16*`shamt`+15 : 16*`shamt`] replaced by `imm16`, and every other bit unchanged.
- R6: After a clock edge where `exec_en` is high and the code is 1 or 2, `flag_n` equals bit 63 of that cycle's result, and `flag_z` is high exactly when that result was zero.
- R7: After such an edge, `flag_c` is the unsigned carry out of the add, or for subtract it is high when no borrow occurred (that is, `opnd_a` >= `opnd_b` unsigned).
- R8: After such an edge, `flag_v` is high exactly when the signed two's-complement operation overflowed.
- R9: At an edge where `exec_en` is low, or the code is not 1 or 2, all four flags keep their values.
- R10: `flag_lt` is high exactly when `flag_n` differs from `flag_v`.
- R11: While `rst_n` is low, and right after it is released, all four flags are zero.
- R12: Codes 5 to 7 drive `result` to zero and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | High when this cycle carries an issued operation |
| op | input | 3 | Operation code (0..4 defined) |
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| opnd_old | input | 64 | Current destination value, used by move keep |
| imm12 | input | 12 | Immediate for add immediate |
| imm16 | input | 16 | Immediate for the move-wide operations |
| shamt | input | 2 | Lane select; shift is 16 times this value |
| result | output | 64 | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_lt | output | 1 | High when negative and overflow flags differ |

## Verification
The only state in this block is the flag register. A wrong flag value therefore appears on the flag pins one clock after the operation that wrote it. It then persists through any number of non-flag cycles until the next flag-setting operation. The bench checks the flags every cycle, including idle and move-wide cycles, so a spurious update or a missed hold shows up at the very next edge. Result errors are purely combinational and are seen in the cycle the inputs are applied, with carry-chain, sign-overflow and lane-boundary corners driven on purpose.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [2:0] {
    OP_ADDI = 3'd0,
    OP_ADDS = 3'd1,
    OP_SUBS = 3'd2,
    OP_MOVZ = 3'd3,
    OP_MOVK = 3'd4
  } exu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } exu_flags_t;
endpackage

// File: rtl/exu_adder.sv
module exu_adder #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    carry = wide[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/exu_movewide.sv
module exu_movewide #(
  parameter int W    = 64,
  parameter int IMMW = 16,
  parameter int SHW  = 2
) (
  input  logic [IMMW-1:0] imm,
  input  logic [SHW-1:0]  sh,
  input  logic            keep,
  input  logic [W-1:0]    old,
  output logic [W-1:0]    out
);
  localparam int LANES = W / IMMW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (sh == SHW'(g))
        out[g*IMMW +: IMMW] = imm;
      else if (keep)
        out[g*IMMW +: IMMW] = old[g*IMMW +: IMMW];
      else
        out[g*IMMW +: IMMW] = '0;
    end
  end
endmodule

// File: rtl/exu_flagreg.sv
module exu_flagreg
  import exu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  exu_flags_t nxt,
  output exu_flags_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= '0;
    else if (upd) cur <= nxt;
  end

  // R9: flags hold when no update is requested
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cur));

  // R6/R7/R8: the register captures the presented flags on update
  p_flags_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> cur == $past(nxt));
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int W    = 64,
  parameter int IMMW = 16,
  parameter int I12W = 12,
  parameter int SHW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic [2:0]      op,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [W-1:0]    opnd_old,
  input  logic [I12W-1:0] imm12,
  input  logic [IMMW-1:0] imm16,
  input  logic [SHW-1:0]  shamt,
  output logic [W-1:0]    result,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_c,
  output logic            flag_v,
  output logic            flag_lt
);
  exu_op_e    op_e;
  logic [W-1:0] add_b, add_sum, mw_out;
  logic       add_sub, add_c, add_v;
  logic       is_flag_op, flag_upd;
  exu_flags_t flags_nxt, flags_cur;

  always_comb begin
    op_e       = exu_op_e'(op);
    add_sub    = (op_e == OP_SUBS);
    add_b      = (op_e == OP_ADDI) ? {{(W-I12W){1'b0}}, imm12} : opnd_b;
    is_flag_op = (op_e == OP_ADDS) || (op_e == OP_SUBS);
    flag_upd   = exec_en && is_flag_op;
  end

  exu_adder #(.W(W)) u_add (
    .a(opnd_a), .b(add_b), .sub(add_sub),
    .sum(add_sum), .carry(add_c), .ovf(add_v)
  );

  exu_movewide #(.W(W), .IMMW(IMMW), .SHW(SHW)) u_mw (
    .imm(imm16), .sh(shamt), .keep(op_e == OP_MOVK),
    .old(opnd_old), .out(mw_out)
  );

  always_comb begin
    case (op_e)
      OP_ADDI, OP_ADDS, OP_SUBS: result = add_sum;
      OP_MOVZ, OP_MOVK:          result = mw_out;
      default:                   result = '0;
    endcase
  end

  always_comb begin
    flags_nxt.n = add_sum[W-1];
    flags_nxt.z = (add_sum == '0);
    flags_nxt.c = add_c;
    flags_nxt.v = add_v;
  end

  exu_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .upd(flag_upd),
    .nxt(flags_nxt), .cur(flags_cur)
  );

  assign flag_n  = flags_cur.n;
  assign flag_z  = flags_cur.z;
  assign flag_c  = flags_cur.c;
  assign flag_v  = flags_cur.v;
  assign flag_lt = flags_cur.n ^ flags_cur.v;

  // R6: zero flag reflects the result seen at the updating edge
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> flag_z == ($past(result) == '0));

  // R6: negative flag is the sign of the result at the updating edge
  p_neg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> flag_n == $past(result[W-1]));

  // R12: unused codes never alter the flags
  p_unused_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 3'd4) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  // R4: move-zero output has at most one nonzero lane region
  p_movz_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_MOVZ) |-> ((result & ~({{(W-IMMW){1'b0}}, {IMMW{1'b1}}} << (IMMW*shamt))) == '0));
endmodule

// File: tb/tb_exu_core.sv
`timescale 1ns/1ps
module tb_exu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0, opnd_old = '0;
  logic [11:0] imm12 = '0;
  logic [15:0] imm16 = '0;
  logic [1:0]  shamt = '0;
  logic [63:0] result;
  logic        flag_n, flag_z, flag_c, flag_v, flag_lt;

  always #2.5 clk = ~clk;

  exu_core dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_old(opnd_old),
    .imm12(imm12), .imm16(imm16), .shamt(shamt),
    .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .flag_lt(flag_lt)
  );

  typedef struct {
    logic [63:0] res;
    logic [3:0]  flg;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic [3:0] model_flags = 4'b0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one operation per cycle, pushes the expected item
  task automatic drive(input bit en, input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] old, input logic [11:0] i12, input logic [15:0] i16,
                       input logic [1:0] sh, input string req);
    item_t it;
    logic [64:0] w;
    logic [63:0] mask, r;
    logic c, v;
    @(negedge clk);
    exec_en = en; op = o; opnd_a = a; opnd_b = b; opnd_old = old;
    imm12 = i12; imm16 = i16; shamt = sh;
    mask = 64'hffff << (16 * sh);
    c = 1'b0; v = 1'b0; r = '0;
    case (o)
      3'd0: r = a + {52'd0, i12};
      3'd1: begin
        w = {1'b0, a} + {1'b0, b}; r = w[63:0]; c = w[64];
        v = (a[63] == b[63]) && (r[63] != a[63]);
      end
      3'd2: begin
        r = a - b; c = (a >= b);
        v = (a[63] != b[63]) && (r[63] != a[63]);
      end
      3'd3: r = ({48'd0, i16} << (16 * sh));
      3'd4: r = (old & ~mask) | ({48'd0, i16} << (16 * sh));
      default: r = '0;
    endcase
    if (en && (o == 3'd1 || o == 3'd2))
      model_flags = {r[63], (r == 64'd0), c, v};
    it.res = r; it.flg = model_flags; it.req = req;
    q.push_back(it);
  endtask

  // monitor: result in the drive cycle, flags one edge later
  initial begin
    item_t prev;
    bit have_prev = 0;
    forever begin
      @(negedge clk);
      #1;
      if (have_prev) begin
        chk({flag_n, flag_z, flag_c, flag_v} == prev.flg,
            {prev.req, " flags (R6 R7 R8 R9)"},
            {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, prev.flg});
        chk(flag_lt == (prev.flg[3] ^ prev.flg[0]), "R10 lt",
            {63'd0, flag_lt}, {63'd0, prev.flg[3] ^ prev.flg[0]});
        have_prev = 0;
      end
      if (q.size() > 0) begin
        prev = q.pop_front();
        have_prev = 1;
        chk(result == prev.res, {prev.req, " result"}, result, prev.res);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset value
    chk({flag_n, flag_z, flag_c, flag_v} == 4'b0, "R11 reset flags", {60'd0, flag_n, flag_z, flag_c, flag_v}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({flag_n, flag_z, flag_c, flag_v} == 4'b0, "R11 after release", {60'd0, flag_n, flag_z, flag_c, flag_v}, 64'd0);

    // R1 add immediate, zero extension of top immediate bit
    drive(1, 3'd0, 64'd5, 64'd0, 64'd0, 12'hfff, 16'd0, 2'd0, "R1");
    drive(1, 3'd0, 64'hffffffffffffffff, 64'd0, 64'd0, 12'd1, 16'd0, 2'd0, "R1 wrap");
    // R2/R7 carry with zero result
    drive(1, 3'd1, 64'hffffffffffffffff, 64'd1, 64'd0, 12'd0, 16'd0, 2'd0, "R2 carry zero");
    // R8 positive overflow, R10 lt
    drive(1, 3'd1, 64'h7fffffffffffffff, 64'd1, 64'd0, 12'd0, 16'd0, 2'd0, "R8 add ovf");
    // R3 equal operands: Z and C set
    drive(1, 3'd2, 64'd42, 64'd42, 64'd0, 12'd0, 16'd0, 2'd0, "R3 equal");
    // R3/R7 borrow
    drive(1, 3'd2, 64'd0, 64'd1, 64'd0, 12'd0, 16'd0, 2'd0, "R7 borrow");
    // R8 negative overflow on subtract
    drive(1, 3'd2, 64'h8000000000000000, 64'd1, 64'd0, 12'd0, 16'd0, 2'd0, "R8 sub ovf");
    // R9: exec_en low flag op leaves flags
    drive(0, 3'd1, 64'd0, 64'd0, 64'd0, 12'd0, 16'd0, 2'd0, "R9 idle");
    // R4/R5 every lane
    for (int s = 0; s < 4; s++) begin
      drive(1, 3'd3, 64'd0, 64'd0, 64'hffffffffffffffff, 12'd0, 16'habcd, s[1:0], "R4 movz");
      drive(1, 3'd4, 64'd0, 64'd0, 64'h0123456789abcdef, 12'd0, 16'h5a5a, s[1:0], "R5 movk");
    end
    // R12 unused codes
    for (int o = 5; o < 8; o++)
      drive(1, o[2:0], 64'd7, 64'd9, 64'd3, 12'd1, 16'd1, 2'd1, "R12 unused");
    // random sweep over all codes
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 7));
      drive(1'($urandom), ro, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            12'($urandom), 16'($urandom), 2'($urandom), "R2 R3 random");
    end
    drive(0, 3'd5, 64'd0, 64'd0, 64'd0, 12'd0, 16'd0, 2'd0, "R9 tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule